// File: doc/BRIEF.md
# Configurable asynchronous serial transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. It advances on a one-cycle enable pulse that arrives at sixteen times the bit rate, so one bit time is a fixed number of those pulses. The baud divisor that makes the pulse lives outside the block. Characters come from an external holding buffer through a valid/ready handshake. The character length, parity mode and stop length are run-time inputs. They are captured when a character is accepted.

Two further controls sit on the line. A break input forces the line low for as long as it is held, and the frame machinery keeps running underneath it. An automatic flow-control mode lets a clear-to-send input hold back new characters. A character that has already started always runs to its end. A status output reports when no character is pending and none is being shifted out.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line is high, `tx_empty` is 1 and `in_ready` is 1 (idle level is high).
- R2: A frame starts with one low start bit, followed by the data bits sent least significant bit first. The count of data bits is set by `char_len`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper data bits are dropped.
- R3: When `parity_en` is 1, one parity bit follows the data bits. With `parity_odd` at 0 it makes the count of ones in data plus parity even, and with `parity_odd` at 1 it makes that count odd. When `parity_en` is 0 no parity bit is sent.
- R4: The line is high during the stop period. With `stop_long` at 0 the stop period lasts 16 ticks. With `stop_long` at 1 it lasts 24 ticks for 5-bit characters and 32 ticks for every other length.
- R5: Every bit lasts `OVS` (16) tick pulses, and a clock cycle without a tick does not advance the frame.
- R6: While `brk` is 1 the line is low, whatever the transmitter state. The frame underneath keeps its timing, and the line returns to the frame's bit when `brk` falls.
- R7: With `cts_auto` at 1 and `cts` at 0, no character is accepted (`in_ready` is 0) and the line stays idle. With `cts_auto` at 0, `cts` has no effect.
- R8: A frame that has already started completes with normal timing even if `cts` drops during it.
- R9: `tx_empty` is 1 only when `in_valid` is 0 and no frame is in progress.
- R10: A character is taken only in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until the frame ends. Framing inputs that change after acceptance do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Enable pulse at 16 times the bit rate |
| in_data | input | 8 | Character from the holding buffer |
| in_valid | input | 1 | Holding buffer has a character |
| in_ready | output | 1 | Transmitter takes the character this cycle |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_long | input | 1 | 0 gives one stop bit; 1 gives 1.5 stop bits (5-bit characters) or 2 stop bits |
| brk | input | 1 | Force the line low |
| cts_auto | input | 1 | Gate new characters on `cts` |
| cts | input | 1 | Clear to send, active high |
| tx_line | output | 1 | Serial output, idle high |
| tx_empty | output | 1 | Nothing pending and nothing shifting |

## Verification
The bench builds the block with the default `OVS` of 16. At that value the fractional stop length is exactly 24 ticks, and whole frames stay short enough that every character length, parity mode and stop setting can be walked in a few thousand cycles. Most runs drive `tick` high in every cycle, so the bench can place samples at bit centres by counting cycles. One run drives `tick` every other cycle to show that the frame advances on ticks and not on clocks.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       stop_long,
  input  logic       brk,
  input  logic       cts_auto,
  input  logic       cts,
  output logic       tx_line,
  output logic       tx_empty
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] LIM_ONE  = CW'(OVS - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic [1:0]    len_q;
  logic          pen_q, par_q, slong_q;

  wire [7:0] dmask = in_data & (8'hFF >> (2'd3 - char_len));
  wire       take  = in_valid && in_ready;

  logic [CW-1:0] lim;
  always_comb begin
    lim = LIM_ONE;
    if (st == S_STOP && slong_q) lim = (len_q == 2'd0) ? LIM_HALF : LIM_TWO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      len_q   <= '0;
      pen_q   <= 1'b0;
      par_q   <= 1'b0;
      slong_q <= 1'b0;
    end else if (take) begin
      st      <= S_START;
      cnt     <= '0;
      idx     <= '0;
      sh      <= dmask;
      len_q   <= char_len;
      pen_q   <= parity_en;
      par_q   <= (^dmask) ^ parity_odd;
      slong_q <= stop_long;
    end else if (st != S_IDLE && tick) begin
      if (cnt != lim) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh  <= sh >> 1;
            idx <= idx + 3'd1;
            if (idx == {1'b0, len_q} + 3'd4) st <= pen_q ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign in_ready = (st == S_IDLE) && (!cts_auto || cts);
  assign tx_empty = (st == S_IDLE) && !in_valid;

  always_comb begin
    case (st)
      S_START: tx_line = 1'b0;
      S_DATA:  tx_line = sh[0];
      S_PAR:   tx_line = par_q;
      default: tx_line = 1'b1;
    endcase
    if (brk) tx_line = 1'b0;
  end

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !brk) |=> !tx_line);

  a_r10_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !tick) |=> ($stable(st) && $stable(cnt)));

  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !brk) |-> tx_line);

  a_r7_cts_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_auto && !cts) |-> !in_ready);

endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] char_len = 2'd3;
  logic parity_en = 1'b0, parity_odd = 1'b0, stop_long = 1'b0;
  logic brk = 1'b0, cts_auto = 1'b0, cts = 1'b1;
  logic tx_line, tx_empty;
  int tests = 0, fails = 0;
  bit finished = 1'b0, tick_toggle = 1'b0;

  always #2 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .char_len(char_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .stop_long(stop_long), .brk(brk), .cts_auto(cts_auto),
    .cts(cts), .tx_line(tx_line), .tx_empty(tx_empty)
  );

  always @(negedge clk) if (tick_toggle) tick <= ~tick;

  // data, char_len, parity_en, parity_odd, stop_long, expected stop ticks
  localparam logic [18:0] VECS [0:7] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 6'd16},
    {8'h3C, 2'd3, 1'b1, 1'b0, 1'b1, 6'd32},
    {8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 6'd16},
    {8'hFB, 2'd0, 1'b1, 1'b0, 1'b1, 6'd24},
    {8'h6A, 2'd1, 1'b1, 1'b1, 1'b1, 6'd32},
    {8'h55, 2'd2, 1'b0, 1'b0, 1'b1, 6'd32},
    {8'h80, 2'd2, 1'b1, 1'b0, 1'b0, 6'd16},
    {8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 6'd16}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] len, input logic pen,
                           input logic podd, input logic slong, input int stop_t,
                           input bit scramble);
    int nb = 5 + int'(len);
    logic [7:0] dm = d & (8'hFF >> (2'd3 - len));
    char_len = len; parity_en = pen; parity_odd = podd; stop_long = slong;
    offer(d);
    chk("R10 ready low after take", in_ready, 1'b0);
    if (scramble) begin
      char_len = ~len; parity_en = ~pen; parity_odd = ~podd; stop_long = ~slong;
    end
    repeat (8) @(negedge clk);
    chk("R2 start bit", tx_line, 1'b0);
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      chk(scramble ? "R10 data bit" : "R2 data bit", tx_line, dm[i]);
    end
    if (pen) begin
      repeat (16) @(negedge clk);
      chk("R3 parity bit", tx_line, (^dm) ^ podd);
    end
    repeat (16) @(negedge clk);
    chk("R4 stop high", tx_line, 1'b1);
    repeat (stop_t - 9) @(negedge clk);
    chk("R4 busy at stop end", tx_empty, 1'b0);
    @(negedge clk);
    chk("R4 R9 empty after stop", tx_empty, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 idle line", tx_line, 1'b1);
    chk("R1 empty", tx_empty, 1'b1);
    chk("R1 ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", tx_line, 1'b1);

    for (int v = 0; v < 8; v++)
      run_frame(VECS[v][18:11], VECS[v][10:9], VECS[v][8], VECS[v][7], VECS[v][6],
                int'(VECS[v][5:0]), 1'b0);

    // R10: framing inputs changed after acceptance are ignored
    run_frame(8'h13, 2'd0, 1'b0, 1'b0, 1'b1, 24, 1'b1);
    char_len = 2'd3; parity_en = 1'b0; parity_odd = 1'b0; stop_long = 1'b0;

    // R5: tick every other cycle doubles the bit length
    tick_toggle = 1'b1;
    offer(8'h01);
    repeat (19) @(negedge clk);
    chk("R5 start still low", tx_line, 1'b0);
    repeat (20) @(negedge clk);
    chk("R5 bit0 after 16 ticks", tx_line, 1'b1);
    while (!tx_empty) @(negedge clk);
    tick_toggle = 1'b0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk);

    // R6: break while idle and mid-frame
    brk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 break idle low", tx_line, 1'b0);
    brk = 1'b0;
    @(negedge clk);
    chk("R6 idle restored", tx_line, 1'b1);
    offer(8'hFF);
    repeat (40) @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    chk("R6 break overrides data", tx_line, 1'b0);
    brk = 1'b0;
    @(negedge clk);
    chk("R6 data resumes", tx_line, 1'b1);
    repeat (160 - 43) @(negedge clk);
    chk("R6 timing kept busy", tx_empty, 1'b0);
    @(negedge clk);
    chk("R6 timing kept empty", tx_empty, 1'b1);

    // R7, R8, R9: flow control
    cts_auto = 1'b1; cts = 1'b0;
    @(negedge clk);
    in_data = 8'h00; in_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 not ready", in_ready, 1'b0);
    chk("R7 line idle", tx_line, 1'b1);
    chk("R9 pending not empty", tx_empty, 1'b0);
    cts = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; cts = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 frame started", tx_line, 1'b0);
    repeat (160 - 9) @(negedge clk);
    chk("R8 frame running", tx_empty, 1'b0);
    @(negedge clk);
    chk("R8 frame completed", tx_empty, 1'b1);
    cts_auto = 1'b0;
    @(negedge clk);
    chk("R7 cts ignored when off", in_ready, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule